// File: doc/BRIEF.md
# Interrupt Pending and Last-Source Controller

The controller collects interrupt requests from a set of peripheral sources and three system exception events (watchdog timeout, main clock failure, watchdog clock failure) into sticky flag registers. When the CPU has interrupts globally enabled, any pending source raises a registered request line to the CPU. When they are disabled, ordinary sources are only recorded, and software polls the pending register instead. Exception flags are always forwarded, whatever the global enable.

The CPU answers a request with a one-cycle acknowledge pulse. On that pulse the controller picks the winning source, clears its flag, and stores the winner's vector index in a read-only register. A single shared handler can then read that register to learn which source it is serving.

Software reaches four registers over a small synchronous bus. Writes are single-cycle. Reads are combinational from the address.

Top module: `ipc_ctrl`

## Requirements
- R1: A high `src_req[i]` at a clock edge sets pending bit i. The pending register is read at address 0, with bit i holding source i.
- R2: Writing address 0 clears every pending bit whose data bit is 1. Bits written with 0 keep their value.
- R3: Writing address 1 sets every pending bit whose data bit is 1. Address 1 always reads 0.
- R4: `cpu_irq` is registered. It is 1 in the cycle after a cycle in which `gie` was 1 and a pending bit was set. With `gie` at 0 and no exception flag set, it is 0, and the pending bits stay readable.
- R5: Address 2 holds the exception flags: bit 0 is watchdog timeout, bit 1 is main clock failure, bit 2 is watchdog clock failure. Each flag is set by its input and cleared by writing 1 to its bit. Bits 7..3 read 0.
- R6: The winner is chosen in this order: exception bit 0, then bit 1, then bit 2, then the enabled pending source with the lowest number. The vector index is 0..2 for the exceptions and 3+i for source i.
- R7: An acknowledge with a winner clears the winner's flag and loads its index into the last-serviced register at the same edge. An acknowledge with no winner changes nothing.
- R8: Address 3 reads the last-serviced register: bits 1..0 and bit 7 are 0, and bits 6..2 hold the index. Writes to address 3 are ignored.
- R9: When a request or exception event arrives in the same cycle as a clear of the same bit, either by software write or by acknowledge, the bit ends up set.
- R10: A set exception flag drives `cpu_irq` high in the next cycle even when `gie` is 0, and it wins over pending sources.
- R11: A synchronous active-high `rst` zeroes all flags, the last-serviced register and `cpu_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NSRC | Per-source request events |
| exc_wdt | input | 1 | Watchdog timeout event |
| exc_posc | input | 1 | Main clock failure event |
| exc_wosc | input | 1 | Watchdog clock failure event |
| gie | input | 1 | Global interrupt enable |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| cpu_irq | output | 1 | Registered request to the CPU |
| cpu_ack | input | 1 | One-cycle acknowledge from the CPU |

## Verification
The bench sweeps all 255 non-zero pending patterns and acknowledges until each pattern is drained. A wrong priority encoder would report the wrong index or clear the wrong bit, and an off-by-one in index packing would show as a shifted last-serviced value. Collisions of a request with a software clear, or with an acknowledge, on the same bit are driven on purpose: a design that lets the clear win drops an event and reads 0. The bench also pulses exceptions with the global enable off and acknowledges with only ordinary sources pending and the enable off. A design that gates exceptions by the enable would never raise `cpu_irq`, and one that services a masked source would change the last-serviced register.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_PSET = 2'd1,
    REG_EXC  = 2'd2,
    REG_LAST = 2'd3
  } ipc_reg_e;

  // exception count; their bit order is also their priority order
  localparam int unsigned NEXC = 3;
endpackage

// File: rtl/ipc_flags.sv
module ipc_flags #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_evt,
  input  logic [W-1:0] clr_sw,
  input  logic [W-1:0] clr_ack,
  output logic [W-1:0] q
);
  // set dominates any clear so an event in the clearing cycle survives
  function automatic logic [W-1:0] flag_next(input logic [W-1:0] cur,
                                             input logic [W-1:0] s,
                                             input logic [W-1:0] c);
    return (cur & ~c) | s;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= flag_next(q, set_evt, clr_sw | clr_ack);
  end
endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter #(
  parameter int unsigned N  = 11,
  parameter int unsigned IW = 5
) (
  input  logic [N-1:0]  cand,
  output logic          valid,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);
  function automatic logic [IW-1:0] first_set(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  function automatic logic [N-1:0] lowest_bit(input logic [N-1:0] v);
    return v & (~v + N'(1));
  endfunction

  assign valid = |cand;
  assign idx   = first_set(cand);
  assign grant = lowest_bit(cand);
endmodule

// File: rtl/ipc_ctrl.sv
module ipc_ctrl
  import ipc_pkg::*;
#(
  parameter int unsigned NSRC = 8,
  parameter int unsigned DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_req,
  input  logic            exc_wdt,
  input  logic            exc_posc,
  input  logic            exc_wosc,
  input  logic            gie,
  input  logic [1:0]      bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            cpu_irq,
  input  logic            cpu_ack
);
  localparam int unsigned NCAND = NEXC + NSRC;
  localparam int unsigned IW    = DW - 3;

  logic [NSRC-1:0]  pend_q;
  logic [NEXC-1:0]  exc_q;
  logic [IW-1:0]    last_q;
  logic             irq_q;

  // named bus events
  logic wr_pend, wr_pset, wr_exc;
  assign wr_pend = bus_wr && (bus_addr == REG_PEND);
  assign wr_pset = bus_wr && (bus_addr == REG_PSET);
  assign wr_exc  = bus_wr && (bus_addr == REG_EXC);

  logic [NSRC-1:0] pend_set, pend_clr_sw, pend_clr_ack;
  logic [NEXC-1:0] exc_set, exc_clr_sw, exc_clr_ack;

  assign pend_set    = src_req | (wr_pset ? bus_wdata[NSRC-1:0] : '0);
  assign pend_clr_sw = wr_pend ? bus_wdata[NSRC-1:0] : '0;
  assign exc_set     = {exc_wosc, exc_posc, exc_wdt};
  assign exc_clr_sw  = wr_exc ? bus_wdata[NEXC-1:0] : '0;

  // arbitration: exceptions occupy the low candidate positions
  logic [NCAND-1:0] cand, grant, ack_clr;
  logic             win_valid, take;
  logic [IW-1:0]    win_idx;

  assign cand = {(gie ? pend_q : NSRC'(0)), exc_q};

  ipc_arbiter #(.N(NCAND), .IW(IW)) u_arb (
    .cand  (cand),
    .valid (win_valid),
    .idx   (win_idx),
    .grant (grant)
  );

  assign take         = cpu_ack && win_valid;
  assign ack_clr      = take ? grant : '0;
  assign pend_clr_ack = ack_clr[NCAND-1:NEXC];
  assign exc_clr_ack  = ack_clr[NEXC-1:0];

  ipc_flags #(.W(NSRC)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .set_evt (pend_set),
    .clr_sw  (pend_clr_sw),
    .clr_ack (pend_clr_ack),
    .q       (pend_q)
  );

  ipc_flags #(.W(NEXC)) u_exc (
    .clk     (clk),
    .rst     (rst),
    .set_evt (exc_set),
    .clr_sw  (exc_clr_sw),
    .clr_ack (exc_clr_ack),
    .q       (exc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (take) last_q <= win_idx;
      irq_q <= win_valid;
    end
  end

  assign cpu_irq = irq_q;

  always_comb begin
    bus_rdata = '0;
    case (ipc_reg_e'(bus_addr))
      REG_PEND: bus_rdata[NSRC-1:0] = pend_q;
      REG_EXC:  bus_rdata[NEXC-1:0] = exc_q;
      REG_LAST: bus_rdata[DW-2:2]   = last_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ipc_ctrl_chk.sv
module ipc_ctrl_chk #(
  parameter int unsigned NSRC = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned NEXC = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            gie,
  input logic            cpu_irq,
  input logic            take,
  input logic [NSRC-1:0] src_req,
  input logic [NSRC-1:0] pend_q,
  input logic [NEXC-1:0] exc_q,
  input logic [DW-4:0]   last_q,
  input logic [1:0]      bus_addr,
  input logic [DW-1:0]   bus_rdata
);
  // R1
  req_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (src_req != '0) |=> ((pend_q & $past(src_req)) == $past(src_req)));

  // R4
  polled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!gie && exc_q == '0) |=> !cpu_irq);

  // R4
  enabled_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (gie && pend_q != '0) |=> cpu_irq);

  // R10
  exc_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_q != '0) |=> cpu_irq);

  // R7
  last_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(last_q));

  // R8
  last_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 2'd3) |-> (bus_rdata[1:0] == 2'b00 && !bus_rdata[DW-1]
                            && bus_rdata[DW-2:2] == last_q));

  // R5
  exc_rsv_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 2'd2) |-> (bus_rdata[DW-1:NEXC] == '0));
endmodule

bind ipc_ctrl ipc_ctrl_chk #(.NSRC(NSRC), .DW(DW), .NEXC(ipc_pkg::NEXC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .gie       (gie),
  .cpu_irq   (cpu_irq),
  .take      (take),
  .src_req   (src_req),
  .pend_q    (pend_q),
  .exc_q     (exc_q),
  .last_q    (last_q),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata)
);

// File: tb/test_ipc_ctrl.sv
module test_ipc_ctrl;
  localparam int unsigned NSRC = 8;
  localparam int unsigned DW   = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst = 1'b1;
  logic [NSRC-1:0] src_req = '0;
  logic            exc_wdt = 1'b0, exc_posc = 1'b0, exc_wosc = 1'b0;
  logic            gie = 1'b0;
  logic [1:0]      bus_addr = 2'd0;
  logic            bus_wr = 1'b0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic            cpu_irq;
  logic            cpu_ack = 1'b0;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;

  ipc_ctrl #(.NSRC(NSRC), .DW(DW)) i_ipc_ctrl (
    .clk(clk), .rst(rst), .src_req(src_req), .exc_wdt(exc_wdt),
    .exc_posc(exc_posc), .exc_wosc(exc_wosc), .gie(gie),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .cpu_ack(cpu_ack)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ack();
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    check(tag, {7'd0, cpu_irq}, {7'd0, exp});
  endtask

  function automatic logic [7:0] last_enc(input int idx);
    return 8'((idx * 4) & 8'h7C);
  endfunction

  task automatic clear_all();
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'hFF);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, exp, lastv;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    rd_chk("R11 pend", 2'd0, 8'h00);
    rd_chk("R11 exc", 2'd2, 8'h00);
    rd_chk("R11 last", 2'd3, 8'h00);
    irq_chk("R11 irq", 1'b0);

    // R1, R2, R3, R4 per-source sweep, polled mode
    for (int i = 0; i < NSRC; i++) begin
      src_req = 8'(1 << i);
      @(negedge clk);
      src_req = '0;
      rd_chk("R1 req sets bit", 2'd0, 8'(1 << i));
      @(negedge clk);
      irq_chk("R4 polled no irq", 1'b0);
      wr(2'd0, 8'h00);
      rd_chk("R2 write 0 keeps", 2'd0, 8'(1 << i));
      wr(2'd0, 8'(1 << i));
      rd_chk("R2 write 1 clears", 2'd0, 8'h00);
      wr(2'd1, 8'(1 << i));
      rd_chk("R3 set register", 2'd0, 8'(1 << i));
      rd_chk("R3 set reads 0", 2'd1, 8'h00);
      wr(2'd0, 8'hFF);
    end

    // R4 forwarding when enabled
    wr(2'd1, 8'h20);
    @(negedge clk);
    irq_chk("R4 disabled quiet", 1'b0);
    gie = 1'b1;
    @(negedge clk);
    @(negedge clk);
    irq_chk("R4 enabled forwards", 1'b1);
    gie = 1'b0;
    clear_all();

    // R6, R7 priority sweep over every pending pattern
    gie = 1'b1;
    for (int p = 1; p < 256; p++) begin
      wr(2'd1, 8'(p));
      exp = 8'(p);
      while (exp != 8'h00) begin
        int low;
        low = 0;
        while (!exp[low]) low++;
        ack();
        exp[low] = 1'b0;
        rd_chk("R7 winner cleared", 2'd0, exp);
        rd_chk("R6 last index", 2'd3, last_enc(3 + low));
      end
    end
    @(negedge clk);
    @(negedge clk);
    irq_chk("R4 drained no irq", 1'b0);

    // R7 acknowledge with nothing eligible (gie off, only source pending)
    gie = 1'b0;
    wr(2'd1, 8'h04);
    rd(2'd3, lastv);
    ack();
    rd_chk("R7 idle ack keeps last", 2'd3, lastv);
    rd_chk("R7 idle ack keeps pend", 2'd0, 8'h04);
    irq_chk("R4 polled pend no irq", 1'b0);
    clear_all();

    // R5, R10 each exception alone with gie off
    for (int e = 0; e < 3; e++) begin
      exc_wdt = (e == 0); exc_posc = (e == 1); exc_wosc = (e == 2);
      @(negedge clk);
      exc_wdt = 1'b0; exc_posc = 1'b0; exc_wosc = 1'b0;
      rd_chk("R5 exc flag set", 2'd2, 8'(1 << e));
      @(negedge clk);
      irq_chk("R10 exc forwarded gie off", 1'b1);
      ack();
      rd_chk("R6 exc index", 2'd3, last_enc(e));
      rd_chk("R7 exc cleared", 2'd2, 8'h00);
    end

    // R10, R6 exceptions win over a source
    gie = 1'b1;
    wr(2'd1, 8'h80);
    exc_wdt = 1'b1; exc_posc = 1'b1; exc_wosc = 1'b1;
    @(negedge clk);
    exc_wdt = 1'b0; exc_posc = 1'b0; exc_wosc = 1'b0;
    for (int e = 0; e < 3; e++) begin
      ack();
      rd_chk("R10 exc before source", 2'd3, last_enc(e));
    end
    ack();
    rd_chk("R6 source after exc", 2'd3, last_enc(10));
    rd_chk("R7 all drained", 2'd0, 8'h00);
    gie = 1'b0;

    // R5 software clear and reserved bits
    exc_wdt = 1'b1; exc_posc = 1'b1; exc_wosc = 1'b1;
    @(negedge clk);
    exc_wdt = 1'b0; exc_posc = 1'b0; exc_wosc = 1'b0;
    wr(2'd2, 8'h00);
    rd_chk("R5 write 0 keeps exc", 2'd2, 8'h07);
    wr(2'd2, 8'h02);
    rd_chk("R5 w1c one exc", 2'd2, 8'h05);
    wr(2'd2, 8'hF8);
    rd_chk("R5 reserved read 0", 2'd2, 8'h05);
    clear_all();

    // R8 read-only last register
    rd(2'd3, lastv);
    wr(2'd3, 8'hFF);
    rd_chk("R8 last write ignored", 2'd3, lastv);

    // R9 collisions
    wr(2'd1, 8'h09);
    src_req = 8'h08;
    wr(2'd0, 8'h09);
    src_req = '0;
    rd_chk("R9 req beats sw clear", 2'd0, 8'h08);
    clear_all();
    gie = 1'b1;
    wr(2'd1, 8'h02);
    src_req = 8'h02;
    ack();
    src_req = '0;
    rd_chk("R9 req beats ack", 2'd0, 8'h02);
    rd_chk("R9 ack still logged", 2'd3, last_enc(4));
    gie = 1'b0;
    clear_all();
    exc_wdt = 1'b1;
    wr(2'd2, 8'h01);
    exc_wdt = 1'b0;
    rd_chk("R9 exc beats clear", 2'd2, 8'h01);

    // R11 reset mid-run
    wr(2'd1, 8'hA5);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd_chk("R11 pend after reset", 2'd0, 8'h00);
    rd_chk("R11 exc after reset", 2'd2, 8'h00);
    rd_chk("R11 last after reset", 2'd3, 8'h00);
    irq_chk("R11 irq after reset", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule